// File: doc/BRIEF.md
# Character Display Byte Write Engine

This block takes one byte at a time from a valid/ready handshake, together with a flag that says whether the byte is a display command or a character to show. It drives the 8-bit parallel bus of a common character-matrix display controller. The bus is made up of eight data lines, a register-select line, a read/write line and an enable strobe. For every accepted byte it places the data and register-select on the bus and lets them settle. It then raises enable for the minimum pulse width, drops it so the display latches the byte on the falling edge, and holds the bus steady afterwards. Last, it waits out the time the display needs to execute the byte before it raises ready again.

Every delay is a count of cycles of the single system clock. The counts are derived from a clock-frequency parameter and rounded up, so the same code meets the display timing at any clock rate. Clearing the screen and returning the cursor home take far longer to execute than other commands, so the block gives those two commands a separate and much longer wait. After reset the block keeps ready low for the display's power-on delay. Initialization sequences and text handling are left to the logic that feeds the handshake.

Top module: `lcd_write_engine`

## Requirements
- R1: Reset state and power-on wait. While reset is held and for exactly PWR_CYC cycles after it is released, ready and enable are low, and data and register-select are 0. ready rises on the PWR_CYC-th rising edge after release. PWR_CYC is 15 ms of clock rounded up, which is 15000 cycles at 1 MHz.
- R2: A byte is accepted on a rising edge where valid and ready are both high. ready is low in the cycle that follows.
- R3: The read/write line is always low.
- R4: On acceptance the byte appears on the data bus. Register-select is driven 0 for a command (flag 0) and 1 for character data (flag 1). Both stay unchanged from acceptance until the next acceptance, which covers the settle time before enable rises and the hold time after it falls.
- R5: Enable rises SETUP_CYC cycles after the accepting edge and stays high for exactly PULSE_CYC cycles. SETUP_CYC is 60 ns rounded up and PULSE_CYC is the smallest count longer than 450 ns, so at 1 MHz both are 1 cycle. Enable is never high while ready is high.
- R6: For an ordinary byte, ready returns exactly SETUP_CYC+PULSE_CYC+HOLD_CYC+SHORT_CYC cycles after the accepting edge. HOLD_CYC is 20 ns rounded up and SHORT_CYC is 40 us rounded up, so at 1 MHz the total is 43 cycles.
- R7: A command byte (flag 0) of value 0x01, 0x02 or 0x03 uses LONG_CYC in place of SHORT_CYC. LONG_CYC is 1.6 ms rounded up, so at 1 MHz the total is 1603 cycles. A character byte of value 0x01 keeps the ordinary wait.
- R8: valid while ready is low is ignored: the data bus and register-select keep the byte in flight, and no extra enable pulse appears.
- R9: Each accepted byte produces exactly one enable pulse, and a valid held high across bytes transfers them back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A byte is offered |
| inReady | output | 1 | Engine idle, byte will be taken |
| inByte | input | 8 | Byte to write |
| inIsData | input | 1 | 1 = character data, 0 = command |
| lcdData | output | 8 | Display data bus |
| lcdRs | output | 1 | Register select |
| lcdRw | output | 1 | Read/write, always write (0) |
| lcdEn | output | 1 | Enable strobe |

## Verification
The hardest case to reach is the wait selection. The long wait must apply only when the flag is 0 and the value is one of the three slow codes, so the stimulus sends 0x01, 0x02 and 0x03 both as commands and as character data, along with a command just outside the set (0x04). A further hard case is a byte offered while the engine is busy. The bench drives a different byte and flag during the wait and then confirms that the bus still holds the earlier byte and that the pulse count has not moved. A reference model keyed on cycles since acceptance is compared with every output on every clock.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_WAIT
  } lcdState_e;

  typedef enum logic [2:0] {
    LD_SETUP,
    LD_PULSE,
    LD_HOLD,
    LD_SHORT,
    LD_LONG
  } loadKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      load;
    loadKind_e kind;
  } ctlStrobe_t;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic longint cyclesAtLeast(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // smallest cycle count strictly longer than ns
  function automatic longint cyclesAbove(input longint ns, input longint hz);
    return (ns * hz) / 64'd1_000_000_000 + 1;
  endfunction

  function automatic longint maxOf(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcdw_datapath.sv
module lcdw_datapath
  import lcdw_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int SETUP_CYC = 3,
  parameter int PULSE_CYC = 23,
  parameter int HOLD_CYC  = 1,
  parameter int SHORT_CYC = 2000,
  parameter int LONG_CYC  = 80000,
  parameter int PWR_CYC   = 750000
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t ctl,
  input  logic [7:0] inByte,
  input  logic       inIsData,
  output logic [7:0] busData,
  output logic       busRs,
  output logic       cntDone,
  output logic       longCmd
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // byte and register-select held until the next capture
  always_ff @(posedge clk) begin
    if (rst) begin
      busData <= '0;
      busRs   <= 1'b0;
    end else if (ctl.capture) begin
      busData <= inByte;
      busRs   <= inIsData;
    end
  end

  // clear (0x01) and home (0x02/0x03) commands need the long wait
  assign longCmd = !busRs && (busData[7:2] == 6'd0) && (busData[1:0] != 2'd0);

  always_comb begin
    unique case (ctl.kind)
      LD_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      LD_PULSE: loadVal = CNT_W'(PULSE_CYC - 1);
      LD_HOLD:  loadVal = CNT_W'(HOLD_CYC - 1);
      LD_SHORT: loadVal = CNT_W'(SHORT_CYC - 1);
      LD_LONG:  loadVal = CNT_W'(LONG_CYC - 1);
      default:  loadVal = '0;
    endcase
  end

  // single down-counter shared by every timed phase
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(PWR_CYC - 1);
    end else if (ctl.load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

endmodule

// File: rtl/lcdw_control.sv
module lcdw_control
  import lcdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       cntDone,
  input  logic       longCmd,
  output ctlStrobe_t ctl,
  output logic       busEn,
  output logic       inReady
);

  lcdState_e state;
  lcdState_e nextState;

  always_comb begin
    nextState = state;
    ctl       = '{capture: 1'b0, load: 1'b0, kind: LD_SETUP};
    unique case (state)
      ST_POWER: if (cntDone) nextState = ST_IDLE;
      ST_IDLE: begin
        if (inValid) begin
          ctl.capture = 1'b1;
          ctl.load    = 1'b1;
          ctl.kind    = LD_SETUP;
          nextState   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cntDone) begin
          ctl.load  = 1'b1;
          ctl.kind  = LD_PULSE;
          nextState = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (cntDone) begin
          ctl.load  = 1'b1;
          ctl.kind  = LD_HOLD;
          nextState = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (cntDone) begin
          ctl.load  = 1'b1;
          ctl.kind  = longCmd ? LD_LONG : LD_SHORT;
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: if (cntDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  // outputs registered from the next state: glitch-free strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_POWER;
      busEn   <= 1'b0;
      inReady <= 1'b0;
    end else begin
      state   <= nextState;
      busEn   <= (nextState == ST_PULSE);
      inReady <= (nextState == ST_IDLE);
    end
  end

endmodule

// File: rtl/lcd_write_engine.sv
module lcd_write_engine
  import lcdw_pkg::*;
#(
  parameter longint CLK_HZ   = 50_000_000,
  parameter longint SETUP_NS = 60,
  parameter longint PULSE_NS = 450,
  parameter longint HOLD_NS  = 20,
  parameter longint SHORT_NS = 40_000,
  parameter longint LONG_NS  = 1_600_000,
  parameter longint PWR_NS   = 15_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inByte,
  input  logic       inIsData,
  output logic [7:0] lcdData,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn
);

  localparam longint SETUP_CYC = cyclesAtLeast(SETUP_NS, CLK_HZ);
  localparam longint PULSE_CYC = cyclesAbove(PULSE_NS, CLK_HZ);
  localparam longint HOLD_CYC  = cyclesAtLeast(HOLD_NS, CLK_HZ);
  localparam longint SHORT_CYC = cyclesAtLeast(SHORT_NS, CLK_HZ);
  localparam longint LONG_CYC  = cyclesAtLeast(LONG_NS, CLK_HZ);
  localparam longint PWR_CYC   = cyclesAtLeast(PWR_NS, CLK_HZ);
  localparam longint MAX_CYC   = maxOf(maxOf(maxOf(SETUP_CYC, PULSE_CYC),
                                             maxOf(HOLD_CYC, SHORT_CYC)),
                                       maxOf(LONG_CYC, PWR_CYC));
  localparam int     CNT_W     = $clog2(MAX_CYC + 1);

  ctlStrobe_t ctl;
  logic       cntDone;
  logic       longCmd;

  lcdw_control u_control (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .cntDone (cntDone),
    .longCmd (longCmd),
    .ctl     (ctl),
    .busEn   (lcdEn),
    .inReady (inReady)
  );

  lcdw_datapath #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (int'(SETUP_CYC)),
    .PULSE_CYC (int'(PULSE_CYC)),
    .HOLD_CYC  (int'(HOLD_CYC)),
    .SHORT_CYC (int'(SHORT_CYC)),
    .LONG_CYC  (int'(LONG_CYC)),
    .PWR_CYC   (int'(PWR_CYC))
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .inByte   (inByte),
    .inIsData (inIsData),
    .busData  (lcdData),
    .busRs    (lcdRs),
    .cntDone  (cntDone),
    .longCmd  (longCmd)
  );

  // write-only engine
  assign lcdRw = 1'b0;

endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int SHORT_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] lcdData,
  input logic       lcdRs,
  input logic       lcdEn
);

  logic enPrev;
  int   enRun;
  int   gap;
  logic sawPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      enPrev   <= 1'b0;
      enRun    <= 0;
      gap      <= 0;
      sawPulse <= 1'b0;
    end else begin
      enPrev <= lcdEn;
      if (lcdEn) enRun <= enPrev ? enRun + 1 : 1;
      if (lcdEn) gap <= 0;
      else if (gap < 32'h3fff_ffff) gap <= gap + 1;
      if (lcdEn) sawPulse <= 1'b1;
    end
  end

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  a_r4_bus_steady_in_pulse: assert property (@(posedge clk) disable iff (rst)
    lcdEn |-> ($stable(lcdData) && $stable(lcdRs)));

  a_r4_bus_hold_after_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdEn) |-> ($stable(lcdData) && $stable(lcdRs)));

  a_r5_no_ready_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !(inReady && lcdEn));

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdEn) |-> (enRun == PULSE_CYC));

  a_r6_exec_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(inReady) && sawPulse) |-> (gap >= HOLD_CYC + SHORT_CYC));

endmodule

bind lcd_write_engine lcdw_checker #(
  .PULSE_CYC (int'(PULSE_CYC)),
  .HOLD_CYC  (int'(HOLD_CYC)),
  .SHORT_CYC (int'(SHORT_CYC))
) u_lcdw_checker (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inReady (inReady),
  .lcdData (lcdData),
  .lcdRs   (lcdRs),
  .lcdEn   (lcdEn)
);

// File: tb/lcd_write_engine_bench.sv
`timescale 1ns/1ps
module lcd_write_engine_bench;

  localparam int CLK_PERIOD_NS = 1000;   // 1 MHz, matches CLK_HZ below
  // cycle counts from the requirements at 1 MHz
  localparam int SET_C   = 1;      // 60 ns rounded up
  localparam int PUL_C   = 1;      // > 450 ns
  localparam int HLD_C   = 1;      // 20 ns rounded up
  localparam int SHORT_C = 40;     // 40 us
  localparam int LONG_C  = 1600;   // 1.6 ms
  localparam int PWR_C   = 15000;  // 15 ms
  localparam int ORD_T   = SET_C + PUL_C + HLD_C + SHORT_C;
  localparam int LONG_T  = SET_C + PUL_C + HLD_C + LONG_C;

  logic       clk;
  logic       rst;
  logic       inValid;
  logic       inReady;
  logic [7:0] inByte;
  logic       inIsData;
  logic [7:0] lcdData;
  logic       lcdRs;
  logic       lcdRw;
  logic       lcdEn;

  lcd_write_engine #(.CLK_HZ(1_000_000)) u_lcd_write_engine (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .inByte   (inByte),
    .inIsData (inIsData),
    .lcdData  (lcdData),
    .lcdRs    (lcdRs),
    .lcdRw    (lcdRw),
    .lcdEn    (lcdEn)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  int    enRises = 0;
  int    accepted = 0;
  bit    cmpOn = 0;
  string readyTag = "R1";

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD_NS / 2) clk = ~clk;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  // reference model: time since acceptance, no state machine
  int       pwrCount;
  int       since;
  int       waitLen;
  bit [7:0] mData;
  bit       mRs;
  bit       mReadyNow;
  bit       prevEn;

  always @(posedge clk) begin
    mReadyNow = (pwrCount >= PWR_C) && (since < 0);
    if (rst) begin
      pwrCount = 0; since = -1; mData = 8'h00; mRs = 1'b0; waitLen = SHORT_C;
    end else if (pwrCount < PWR_C) begin
      pwrCount++;
    end else if (since >= 0) begin
      since++;
      if (since == SET_C + PUL_C + HLD_C + waitLen) since = -1;
    end else if (inValid && mReadyNow) begin
      since = 0;
      mData = inByte;
      mRs   = inIsData;
      waitLen = (!inIsData && inByte >= 8'h01 && inByte <= 8'h03) ? LONG_C : SHORT_C;
    end
  end

  always @(negedge clk) begin
    if (!rst && lcdEn && !prevEn) enRises++;
    prevEn = lcdEn;
    if (cmpOn && !rst) begin
      check(readyTag, "ready", 32'(inReady), 32'((pwrCount >= PWR_C) && (since < 0)));
      check("R5", "enable", 32'(lcdEn),
            32'((since >= SET_C) && (since < SET_C + PUL_C)));
      check("R3", "rw", 32'(lcdRw), 32'd0);
      check("R4", "data", 32'(lcdData), 32'(mData));
      check("R4", "rs", 32'(lcdRs), 32'(mRs));
    end
  end

  // offer a byte, wait for acceptance, return cycles until ready again
  task automatic sendTimed(input logic [7:0] b, input logic d, output int cyc);
    @(negedge clk);
    inValid = 1'b1; inByte = b; inIsData = d;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    accepted++;
    inValid = 1'b0;
    check("R2", "ready after accept", 32'(inReady), 32'd0);
    cyc = 0;
    while (!inReady) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int cyc;
    int rises;
    rst = 1'b1; inValid = 1'b0; inByte = 8'h00; inIsData = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 32'(inReady), 32'd0);
    check("R1", "enable in reset", 32'(lcdEn), 32'd0);
    rst = 1'b0;
    cmpOn = 1;
    readyTag = "R1";
    repeat (PWR_C - 1) @(negedge clk);
    check("R1", "ready before power wait ends", 32'(inReady), 32'd0);
    check("R1", "data during power wait", 32'(lcdData), 32'd0);
    @(negedge clk);
    check("R1", "ready after power wait", 32'(inReady), 32'd1);

    readyTag = "R6";
    sendTimed(8'h38, 1'b0, cyc);
    check("R6", "command wait", 32'(cyc), 32'(ORD_T));
    check("R4", "rs for command", 32'(lcdRs), 32'd0);
    check("R4", "bus byte", 32'(lcdData), 32'h38);
    sendTimed(8'h57, 1'b1, cyc);
    check("R6", "data wait", 32'(cyc), 32'(ORD_T));
    check("R4", "rs for data", 32'(lcdRs), 32'd1);

    readyTag = "R7";
    sendTimed(8'h01, 1'b0, cyc);
    check("R7", "clear wait", 32'(cyc), 32'(LONG_T));
    sendTimed(8'h02, 1'b0, cyc);
    check("R7", "home 02 wait", 32'(cyc), 32'(LONG_T));
    sendTimed(8'h03, 1'b0, cyc);
    check("R7", "home 03 wait", 32'(cyc), 32'(LONG_T));
    sendTimed(8'h01, 1'b1, cyc);
    check("R7", "data 01 wait", 32'(cyc), 32'(ORD_T));
    sendTimed(8'h04, 1'b0, cyc);
    check("R7", "command 04 wait", 32'(cyc), 32'(ORD_T));

    // R8: offer another byte while busy
    readyTag = "R8";
    @(negedge clk);
    inValid = 1'b1; inByte = 8'h0C; inIsData = 1'b0;
    @(negedge clk);
    accepted++;
    rises = enRises;
    inByte = 8'hAA; inIsData = 1'b1;
    repeat (20) @(negedge clk);
    inValid = 1'b0;
    check("R8", "bus kept in flight byte", 32'(lcdData), 32'h0C);
    check("R8", "rs kept", 32'(lcdRs), 32'd0);
    check("R8", "single pulse while busy", 32'(enRises - rises), 32'd1);
    while (!inReady) @(negedge clk);
    check("R8", "no pulse after ignored offer", 32'(enRises - rises), 32'd1);

    // R9: back-to-back with valid held high
    readyTag = "R9";
    @(negedge clk);
    inValid = 1'b1; inByte = 8'h41; inIsData = 1'b1;
    @(negedge clk);
    accepted++;
    inByte = 8'h42;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    accepted++;
    inValid = 1'b0;
    check("R9", "second byte on bus", 32'(lcdData), 32'h42);
    while (!inReady) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9", "pulses per accepted byte", 32'(enRises), 32'(accepted));
    finishRun();
  end

endmodule